// File: doc/BRIEF.md
# Interrupt Vector Fetch Unit

This block turns a selected interrupt vector number into a new program counter value. It adds four times the vector number to a relocatable table base register and reads the 24-bit handler address at that location over a simple single-outstanding memory read port. It then presents the word as a one-cycle program counter load. The word is the handler's address itself, not an instruction. If the memory reports a bus error on that read, the block loads a programmable fallback address instead of the returned data.

After reset the block first reads the fixed reset location, whatever the table base holds. It delivers that word as the start address and copies it into the fallback register, so the fallback defaults to the reset entry's contents. Only after that does it accept vector requests. Three settings are written through a small register port: the table base, the fallback address, and a collapse bit that sends every shared peripheral vector to one common entry. Each of the three can be write-locked until the next reset. A write to a locked setting is dropped and raises a sticky error flag.

Top module: `vector_fetch_unit`

## Requirements
- R1: While reset is held, reqReady, pcLoad, memRdEn and lockErr are all 0.
- R2: The first read after reset is issued at address 0x800000 whatever the table base holds, and its word (or the fallback on a bus error) is delivered as the start address.
- R3: A successful reset read also loads its word into the fallback register, so a later erroring fetch delivers the reset entry's contents until software writes the fallback.
- R4: A request for vector v reads address base + 4*v, truncated to 24 bits, with the base reset to 0x800000.
- R5: A request is accepted in a cycle where reqValid and reqReady are both high. memRdEn pulses for one cycle in the next cycle. pcLoad pulses for one cycle, one cycle after memRdValid. reqReady stays low from acceptance through the pcLoad cycle.
- R6: On a read without error, pcTarget with pcLoad equals memRdData.
- R7: On a read with memRdErr set, pcTarget equals the current fallback register value.
- R8: Writing regSel=0 sets the base and regSel=1 sets the fallback (both from regWdata), when unlocked. Requests accepted afterwards use the new value.
- R9: Writing regSel=3 sets lock bits from regWdata (bit 0 base, bit 1 fallback, bit 2 collapse). A lock bit cannot be cleared by a write, only by reset.
- R10: A write to a locked setting leaves that setting unchanged and sets lockErr, which stays 1 until reset.
- R11: Writing regSel=2 sets the collapse bit from regWdata bit 0. While it is 1, vectors of 9 and above read the entry of vector 9, and lower vectors are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Vector request present |
| reqVector | input | 9 | Vector number |
| reqReady | output | 1 | Block idle and ready for a request |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | 0 base, 1 fallback, 2 collapse, 3 lock |
| regWdata | input | 24 | Write data |
| lockErr | output | 1 | Sticky flag for a write to a locked setting |
| memRdEn | output | 1 | One-cycle read request |
| memAddr | output | 24 | Read address |
| memRdValid | input | 1 | Read response present |
| memRdData | input | 24 | Read word |
| memRdErr | input | 1 | Bus error on the response |
| pcLoad | output | 1 | One-cycle program counter load strobe |
| pcTarget | output | 24 | New program counter value |

## Verification
A wrong base, collapse bit or lock bit appears on memAddr in the cycle after the next accepted request. A corrupted fallback register only appears on pcTarget at the next erroring read, so the stimulus injects bus errors both before and after the fallback is rewritten or locked. A control state that is off by one shows up on the same clock as a misplaced memRdEn, a missing pcLoad pulse or a reqReady level that disagrees with the model. A lost reset-read seed is exposed by the first erroring fetch made before any software write to the fallback.

// File: rtl/vector_fetch_pkg.sv
package vector_fetch_pkg;

  typedef enum logic [1:0] {
    FS_IDLE    = 2'd0,
    FS_ISSUE   = 2'd1,
    FS_WAIT    = 2'd2,
    FS_DELIVER = 2'd3
  } fetchState_e;

  // Codes 0..2 are the lockable settings, in the bit order of the lock register.
  localparam logic [1:0] SEL_BASE     = 2'd0;
  localparam logic [1:0] SEL_FAIL     = 2'd1;
  localparam logic [1:0] SEL_COLLAPSE = 2'd2;
  localparam logic [1:0] SEL_LOCK     = 2'd3;
  localparam int LOCK_N = 3;

  typedef struct packed {
    logic latchAddr;  // capture the entry address of an accepted request
    logic useReset;   // current fetch targets the fixed reset location
    logic capture;    // read response arrives this cycle
    logic seed;       // reset read response: seed the fallback register
  } ctrlStrobe_t;

endpackage

// File: rtl/vector_fetch_ctrl.sv
module vector_fetch_ctrl
  import vector_fetch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRdValid,
  output logic        reqReady,
  output logic        memRdEn,
  output logic        pcLoad,
  output ctrlStrobe_t strobe
);

  fetchState_e state;
  logic        resetPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= FS_IDLE;
      resetPending <= 1'b1;
    end else begin
      unique case (state)
        FS_IDLE:    if (resetPending || reqValid) state <= FS_ISSUE;
        FS_ISSUE:   state <= FS_WAIT;
        FS_WAIT:    if (memRdValid) state <= FS_DELIVER;
        FS_DELIVER: begin
          state        <= FS_IDLE;
          resetPending <= 1'b0;
        end
        default:    state <= FS_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady         = (state == FS_IDLE) && !resetPending;
    memRdEn          = (state == FS_ISSUE);
    pcLoad           = (state == FS_DELIVER);
    strobe.latchAddr = reqReady && reqValid;
    strobe.useReset  = resetPending;
    strobe.capture   = (state == FS_WAIT) && memRdValid;
    strobe.seed      = strobe.capture && resetPending;
  end

endmodule

// File: rtl/vector_fetch_datapath.sv
module vector_fetch_datapath
  import vector_fetch_pkg::*;
#(
  parameter int              ADDR_W      = 24,
  parameter int              VEC_W       = 9,
  parameter int              SHARED_VEC  = 9,
  parameter int              ENTRY_SHIFT = 2,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 24'h800000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [VEC_W-1:0]  reqVector,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic [ADDR_W-1:0] memRdData,
  input  logic              memRdErr,
  output logic              lockErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] pcTarget
);

  localparam logic [VEC_W-1:0] SHARED_IDX = VEC_W'(SHARED_VEC);

  logic [ADDR_W-1:0] baseReg, failReg, addrReg, targetReg, entryAddr;
  logic              collapseReg;
  logic [LOCK_N-1:0] lockBit, writeHit, allowed;
  logic [VEC_W-1:0]  effVec;
  logic              lockWrite;

  assign lockWrite = regWe && (regSel == SEL_LOCK);

  for (genvar i = 0; i < LOCK_N; i++) begin : g_lock
    logic bitQ;
    always_ff @(posedge clk) begin
      if (!rstN)                         bitQ <= 1'b0;
      else if (lockWrite && regWdata[i]) bitQ <= 1'b1;
    end
    assign lockBit[i]  = bitQ;
    assign writeHit[i] = regWe && (regSel == 2'(i));
    assign allowed[i]  = writeHit[i] && !bitQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg     <= RESET_ADDR;
      failReg     <= RESET_ADDR;
      collapseReg <= 1'b0;
      lockErr     <= 1'b0;
    end else begin
      if (|(writeHit & lockBit)) lockErr <= 1'b1;
      if (allowed[SEL_BASE]) baseReg <= regWdata;
      if (strobe.seed && !memRdErr)  failReg <= memRdData;
      else if (allowed[SEL_FAIL])    failReg <= regWdata;
      if (allowed[SEL_COLLAPSE]) collapseReg <= regWdata[0];
    end
  end

  always_comb begin
    effVec    = (collapseReg && (reqVector >= SHARED_IDX)) ? SHARED_IDX : reqVector;
    entryAddr = baseReg + (ADDR_W'(effVec) << ENTRY_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      targetReg <= '0;
    end else begin
      if (strobe.latchAddr) addrReg <= entryAddr;
      if (strobe.capture)   targetReg <= memRdErr ? failReg : memRdData;
    end
  end

  assign memAddr  = strobe.useReset ? RESET_ADDR : addrReg;
  assign pcTarget = targetReg;

endmodule

// File: rtl/vector_fetch_unit.sv
module vector_fetch_unit
  import vector_fetch_pkg::*;
#(
  parameter int              ADDR_W      = 24,
  parameter int              VEC_W       = 9,
  parameter int              SHARED_VEC  = 9,
  parameter int              ENTRY_SHIFT = 2,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 24'h800000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VEC_W-1:0]  reqVector,
  output logic              reqReady,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [ADDR_W-1:0] regWdata,
  output logic              lockErr,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdValid,
  input  logic [ADDR_W-1:0] memRdData,
  input  logic              memRdErr,
  output logic              pcLoad,
  output logic [ADDR_W-1:0] pcTarget
);

  ctrlStrobe_t strobe;

  vector_fetch_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .memRdValid (memRdValid),
    .reqReady   (reqReady),
    .memRdEn    (memRdEn),
    .pcLoad     (pcLoad),
    .strobe     (strobe)
  );

  vector_fetch_datapath #(
    .ADDR_W      (ADDR_W),
    .VEC_W       (VEC_W),
    .SHARED_VEC  (SHARED_VEC),
    .ENTRY_SHIFT (ENTRY_SHIFT),
    .RESET_ADDR  (RESET_ADDR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqVector (reqVector),
    .regWe     (regWe),
    .regSel    (regSel),
    .regWdata  (regWdata),
    .memRdData (memRdData),
    .memRdErr  (memRdErr),
    .lockErr   (lockErr),
    .memAddr   (memAddr),
    .pcTarget  (pcTarget)
  );

endmodule

// File: rtl/vector_fetch_unit_chk.sv
module vector_fetch_unit_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic lockErr,
  input logic memRdEn,
  input logic memRdValid,
  input logic pcLoad
);

  // R5
  pc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !pcLoad);

  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  // R5
  accept_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> memRdEn);

  // R5
  load_after_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> $past(memRdValid));

  // R5
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || pcLoad) |-> !reqReady);

  // R10
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockErr |=> lockErr);

endmodule

bind vector_fetch_unit vector_fetch_unit_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .lockErr    (lockErr),
  .memRdEn    (memRdEn),
  .memRdValid (memRdValid),
  .pcLoad     (pcLoad)
);

// File: tb/sim_vector_fetch_unit.sv
`timescale 1ns/1ps
module sim_vector_fetch_unit;

  localparam logic [23:0] RST_LOC = 24'h800000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [8:0]  reqVector = '0;
  logic        reqReady;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = '0;
  logic [23:0] regWdata = '0;
  logic        lockErr;
  logic        memRdEn;
  logic [23:0] memAddr;
  logic        memRdValid = 1'b0;
  logic [23:0] memRdData = '0;
  logic        memRdErr = 1'b0;
  logic        pcLoad;
  logic [23:0] pcTarget;

  always #5 clk = ~clk;

  vector_fetch_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVector(reqVector),
    .reqReady(reqReady), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .lockErr(lockErr), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdValid(memRdValid), .memRdData(memRdData), .memRdErr(memRdErr),
    .pcLoad(pcLoad), .pcTarget(pcTarget)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit injErr = 0;

  function automatic logic [23:0] memWord(logic [23:0] a);
    return (a ^ 24'h5A3C0F) + {a[11:0], a[23:12]};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference state
  logic [23:0] mBase, mFail, curAddr, stubAddr;
  logic        mCol, mErr, curReset, failWritten, baseWritten, curCollapsed;
  logic [2:0]  mLocks;
  bit          pending, prevReady, prevRst, lastLoad;
  int          stubCnt, fetchNo;

  always @(negedge clk) begin
    if (!rstN) begin
      mBase = RST_LOC; mFail = RST_LOC; mCol = 0; mErr = 0; mLocks = '0;
      failWritten = 0; baseWritten = 0; curCollapsed = 0;
      pending = 1; prevReady = 0; prevRst = 0; lastLoad = 0; stubCnt = 0;
      curAddr = RST_LOC; curReset = 1;
      memRdValid <= 1'b0;
    end else begin
      automatic bit startRst = !prevRst;
      automatic bit acc = reqValid && prevReady;
      automatic bit expLoad = memRdValid;
      // delivery of the response present at the last edge
      chk(pcLoad == expLoad, "R5 pcLoad timing", pcLoad, expLoad);
      if (expLoad) begin
        automatic logic [23:0] expT = memRdErr ? mFail : memWord(curAddr);
        automatic string tg = memRdErr ? (failWritten ? "R7 fallback target" : "R3 seeded fallback")
                                       : (curReset ? "R2 start address" : "R6 handler target");
        chk(pcTarget == expT, tg, pcTarget, expT);
        if (curReset && !memRdErr) mFail = expT;
      end
      // issue of a new read
      if (acc) begin
        automatic logic [8:0] v = (mCol && reqVector >= 9) ? 9'd9 : reqVector;
        curCollapsed = mCol && reqVector >= 9;
        curAddr = mBase + {13'd0, v, 2'b00};
        curReset = 0;
      end
      if (startRst) begin curAddr = RST_LOC; curReset = 1; end
      chk(memRdEn == (acc || startRst), "R5 read strobe", memRdEn, acc || startRst);
      if (memRdEn) begin
        automatic string ta = curReset ? "R2 reset location" : curCollapsed ? "R11 collapsed entry"
                            : baseWritten ? "R8 moved base" : "R4 entry address";
        chk(memAddr == curAddr, ta, memAddr, curAddr);
      end
      // register writes at the last edge
      if (regWe) begin
        if (regSel == 2'd3) mLocks = mLocks | regWdata[2:0];
        else if (mLocks[regSel]) mErr = 1;
        else if (regSel == 2'd0) begin mBase = regWdata; baseWritten = 1; end
        else if (regSel == 2'd1) begin mFail = regWdata; failWritten = 1; end
        else mCol = regWdata[0];
      end
      chk(lockErr == mErr, "R10 R9 lock error flag", lockErr, mErr);
      // readiness
      if (lastLoad) pending = 0;
      if (acc || startRst) pending = 1;
      chk(reqReady == !pending, "R5 ready level", reqReady, !pending);
      lastLoad = expLoad;
      prevReady = reqReady;
      prevRst = 1;
      // memory stub
      if (memRdEn) begin
        stubAddr = memAddr; stubCnt = 1 + fetchNo % 3; fetchNo++;
        memRdValid <= 1'b0;
      end else if (stubCnt > 0) begin
        stubCnt--;
        if (stubCnt == 0) begin
          memRdValid <= 1'b1; memRdData <= memWord(stubAddr); memRdErr <= injErr;
        end else memRdValid <= 1'b0;
      end else memRdValid <= 1'b0;
    end
  end

  task automatic fetch(logic [8:0] vec, bit err);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    #1 reqValid = 1; reqVector = vec; injErr = err;
    @(negedge clk);
    #1 reqValid = 0;
    do @(negedge clk); while (!pcLoad);
  endtask

  task automatic wr(logic [1:0] sel, logic [23:0] d);
    @(negedge clk);
    #1 regWe = 1; regSel = sel; regWdata = d;
    @(negedge clk);
    #1 regWe = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    fetchNo = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reqReady == 0, "R1 ready in reset", reqReady, 0);
    chk(pcLoad == 0, "R1 pcLoad in reset", pcLoad, 0);
    chk(memRdEn == 0, "R1 read in reset", memRdEn, 0);
    chk(lockErr == 0, "R1 lockErr in reset", lockErr, 0);
    #1 rstN = 1;
    // R2/R3 reset read, then R4/R6 plain fetches and R3 seeded fallback
    fetch(9'd5, 0);
    fetch(9'd0, 0);
    fetch(9'd20, 1);
    // R8 moved base, highest vector
    wr(2'd0, 24'h001000);
    fetch(9'd364, 0);
    fetch(9'd511, 0);
    // R7 programmed fallback
    wr(2'd1, 24'h0ABCDE);
    fetch(9'd3, 1);
    // R11 collapse
    wr(2'd2, 24'h000001);
    fetch(9'd100, 0);
    fetch(9'd9, 0);
    fetch(9'd8, 0);
    // R9 lock base, R10 ignored write
    wr(2'd3, 24'h000001);
    wr(2'd0, 24'h222222);
    fetch(9'd1, 0);
    // R9 a zero lock write does not unlock
    wr(2'd3, 24'h000000);
    wr(2'd0, 24'h333333);
    fetch(9'd2, 0);
    // R9 lock fallback and collapse
    wr(2'd3, 24'h000006);
    wr(2'd2, 24'h000000);
    wr(2'd1, 24'h444444);
    fetch(9'd50, 1);
    // R5 back-to-back requests held valid
    @(negedge clk);
    #1 reqValid = 1; reqVector = 9'd7; injErr = 0;
    repeat (25) @(negedge clk);
    #1 reqValid = 0;
    repeat (10) @(negedge clk);
    finishRun();
  end

endmodule